// File: doc/BRIEF.md
# VLIW Execute-Packet Dispatch Splitter

This block sits between program fetch and decode in a VLIW core. It runs a four-stage program-fetch pipeline: address generate, address send, wait and receive. The pipeline delivers one fetch packet of eight 32-bit instruction words at a time into a dispatch register. In dispatch, the block reads the parallel bit of each word to find the groups of words that issue together. It sends one such execute packet per cycle to decode, as a slot mask together with the eight words of the packet.

A fetch packet split into N execute packets stays in dispatch for N cycles. For the first N-1 of those cycles the block raises a stall. The stall freezes every fetch stage, and no new fetch address is generated while it is high. The next fetch packet enters dispatch in the cycle after the last execute packet has gone out. Program memory is modelled as a request with a fixed one-cycle response.

Top module: `vliw_dispatch_split`

## Requirements
- R1: Bit 0 of each word is its parallel bit. A 1 joins the next slot to the same execute packet, and a 0 closes the packet. The mask is a contiguous run of slots that starts at the first slot not yet issued.
- R2: Slot 7 always closes an execute packet, even when its parallel bit is 1, so a packet never crosses into the next fetch packet.
- R3: While dispatch holds a fetch packet, one execute packet is issued per cycle, in slot order. ep_words_o carries the eight words of the current fetch packet.
- R4: fetch_stall_o is 1 exactly when dispatch holds a fetch packet and the execute packet now being issued does not contain slot 7.
- R5: While fetch_stall_o is 1, every fetch stage holds its contents and mem_req_o stays 0. The next fetch packet enters dispatch in the cycle after the last execute packet leaves.
- R6: Fetch addresses start at 0 after reset and increase by one per request with no gaps. The first execute packet is valid after the fifth rising clock edge following reset release.
- R7: A fetch packet whose slots 0 to 6 all have parallel bit 1 is issued in one cycle with mask 8'hFF and no stall.
- R8: While reset is active, ep_valid_o, ep_mask_o, fetch_stall_o and mem_req_o are all 0.
- R9: Read data arrives one cycle after its request. The data is held in the wait stage if a stall keeps the fetch packet there, and it reaches dispatch unchanged.
- R10: ep_mask_o is 0 whenever ep_valid_o is 0, and it is non-zero whenever ep_valid_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_o | output | 1 | Program memory read request |
| mem_addr_o | output | ADDR_W | Fetch packet index to read |
| mem_rvalid_i | input | 1 | Read data valid, one cycle after request |
| mem_rdata_i | input | 256 | Eight instruction words, slot i at bits 32*i+31:32*i |
| ep_valid_o | output | 1 | Execute packet valid this cycle |
| ep_mask_o | output | 8 | Slots in the current execute packet |
| ep_words_o | output | 256 | Words of the fetch packet in dispatch |
| fetch_stall_o | output | 1 | Freezes the fetch pipeline |

## Verification
The assertions check a set of cycle-level rules on every cycle. A stall needs a valid packet in dispatch and keeps the dispatched words stable. The fetch stages do not move under a stall. Request addresses advance by one. A valid packet always has a non-empty mask. Only the bench scenarios can show that the split is correct for each parallel-bit pattern. They also show the end-of-slot rule, the exact length of each stall, the latency from reset to the first packet, and that read data caught during a stall arrives in dispatch intact.

// File: rtl/vds_pkg.sv
package vds_pkg;
  localparam int unsigned SLOTS  = 8;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned PTR_W  = $clog2(SLOTS);
  localparam int unsigned FP_W   = SLOTS * WORD_W;
  localparam int unsigned PBIT   = 0;
  typedef logic [FP_W-1:0]  fp_t;
  typedef logic [SLOTS-1:0] mask_t;
  typedef logic [PTR_W-1:0] ptr_t;
endpackage

// File: rtl/vds_fetch_pipe.sv
module vds_fetch_pipe
  import vds_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  fp_t               mem_rdata_i,
  output logic              pr_valid_o,
  output fp_t               pr_data_o
);
  localparam int unsigned NSTG = 4;
  localparam int unsigned PG = 0, PS = 1, PW = 2, PR = 3;

  logic [NSTG-1:0]   stg_v;
  logic [ADDR_W-1:0] pc_q, pg_addr, ps_addr;
  fp_t               pw_data, pr_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_v   <= '0;
      pc_q    <= '0;
      pg_addr <= '0;
      ps_addr <= '0;
      pr_data <= '0;
    end else if (!stall_i) begin
      stg_v   <= {stg_v[NSTG-2:0], 1'b1};
      pc_q    <= pc_q + 1'b1;
      pg_addr <= pc_q;
      ps_addr <= pg_addr;
      // data bypasses wait-stage buffer when it arrives on the advancing edge
      pr_data <= mem_rvalid_i ? mem_rdata_i : pw_data;
    end
  end

  // wait-stage buffer keeps a response that lands under a stall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pw_data <= '0;
    else if (mem_rvalid_i) pw_data <= mem_rdata_i;
  end

  assign mem_req_o  = stg_v[PS] & ~stall_i;
  assign mem_addr_o = ps_addr;
  assign pr_valid_o = stg_v[PR];
  assign pr_data_o  = pr_data;

  // R5
  stage_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable({stg_v, pg_addr, ps_addr, pc_q}));
  // R6
  addr_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> mem_addr_o == $past(mem_addr_o) + 1'b1);
  // R9
  resp_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |-> stg_v[PW]);
endmodule

// File: rtl/vds_ep_scan.sv
module vds_ep_scan
  import vds_pkg::*;
(
  input  fp_t   words_i,
  input  ptr_t  start_i,
  output mask_t mask_o,
  output logic  last_o
);
  mask_t pbit;
  logic  run;

  for (genvar s = 0; s < SLOTS; s++) begin : g_pbit
    assign pbit[s] = words_i[s*WORD_W + PBIT];
  end

  always_comb begin
    mask_o = '0;
    run    = 1'b1;
    for (int i = 0; i < SLOTS; i++) begin
      if (i >= int'(start_i) && run) begin
        mask_o[i] = 1'b1;
        if (!pbit[i]) run = 1'b0;
      end
    end
  end

  // slot SLOTS-1 always closes the packet
  assign last_o = mask_o[SLOTS-1];
endmodule

// File: rtl/vds_dispatch.sv
module vds_dispatch
  import vds_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pr_valid_i,
  input  fp_t   pr_data_i,
  output logic  ep_valid_o,
  output mask_t ep_mask_o,
  output fp_t   ep_words_o,
  output logic  stall_o
);
  logic  dp_v;
  fp_t   dp_data;
  ptr_t  ptr_q;
  mask_t scan_mask;
  logic  scan_last;

  vds_ep_scan u_scan (
    .words_i (dp_data),
    .start_i (ptr_q),
    .mask_o  (scan_mask),
    .last_o  (scan_last)
  );

  assign stall_o = dp_v & ~scan_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_v    <= 1'b0;
      dp_data <= '0;
      ptr_q   <= '0;
    end else if (stall_o) begin
      ptr_q <= ptr_q + PTR_W'($countones(scan_mask));
    end else begin
      dp_v    <= pr_valid_i;
      dp_data <= pr_data_i;
      ptr_q   <= '0;
    end
  end

  assign ep_valid_o = dp_v;
  assign ep_mask_o  = dp_v ? scan_mask : '0;
  assign ep_words_o = dp_data;

  // R4
  stall_has_fp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ep_valid_o);
  // R3
  fp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> ep_valid_o && $stable(ep_words_o));
  // R10
  mask_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_valid_o |-> ep_mask_o != '0);
  // R1
  ptr_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> ep_mask_o != $past(ep_mask_o));
endmodule

// File: rtl/vliw_dispatch_split.sv
module vliw_dispatch_split
  import vds_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [FP_W-1:0]   mem_rdata_i,
  output logic              ep_valid_o,
  output logic [SLOTS-1:0]  ep_mask_o,
  output logic [FP_W-1:0]   ep_words_o,
  output logic              fetch_stall_o
);
  logic pr_valid;
  fp_t  pr_data;
  logic stall;

  vds_fetch_pipe #(.ADDR_W(ADDR_W)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stall_i      (stall),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .pr_valid_o   (pr_valid),
    .pr_data_o    (pr_data)
  );

  vds_dispatch u_disp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pr_valid_i (pr_valid),
    .pr_data_i  (pr_data),
    .ep_valid_o (ep_valid_o),
    .ep_mask_o  (ep_mask_o),
    .ep_words_o (ep_words_o),
    .stall_o    (stall)
  );

  assign fetch_stall_o = stall;

  // R5
  no_req_in_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_stall_o |=> !$past(mem_req_o));
endmodule

// File: tb/vliw_dispatch_split_tb.sv
module vliw_dispatch_split_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 16;
  localparam int N_FP       = 24;
  localparam int WDOG       = 5000;

  typedef struct {
    logic [7:0]   mask;
    logic [255:0] words;
    logic         stall;
    string        tag;
  } exp_t;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           mem_req;
  logic [AW-1:0]  mem_addr;
  logic           mem_rvalid = 0;
  logic [255:0]   mem_rdata = '0;
  logic           ep_valid;
  logic [7:0]     ep_mask;
  logic [255:0]   ep_words;
  logic           stall;

  int checks = 0, fails = 0;
  exp_t exp_q[$];
  int exp_req = 0;
  int edges = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vliw_dispatch_split #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .ep_valid_o(ep_valid), .ep_mask_o(ep_mask),
    .ep_words_o(ep_words), .fetch_stall_o(stall)
  );

  function automatic logic [7:0] pat_of(int a);
    case (a % 8)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h7F;
      3: return 8'h0A;
      4: return 8'h81;
      5: return 8'h3C;
      6: return 8'h55;
      default: return 8'hE0;
    endcase
  endfunction

  function automatic logic [255:0] fp_words(int a);
    logic [255:0] w;
    logic [7:0] p;
    p = pat_of(a);
    for (int i = 0; i < 8; i++)
      w[32*i +: 32] = {a[19:0], 3'(i), 8'h5A, p[i]};
    return w;
  endfunction

  task automatic check(string req, logic [255:0] act, logic [255:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // driver: expected execute packets per fetch packet
  task automatic push_fp(int a);
    logic [7:0] p;
    int s, e;
    p = pat_of(a);
    s = 0;
    while (s < 8) begin
      exp_t it;
      e = s;
      while (e < 7 && p[e]) e++;
      it.mask = '0;
      for (int k = s; k <= e; k++) it.mask[k] = 1'b1;
      it.words = fp_words(a);
      it.stall = (e != 7);
      if (p == 8'h7F) it.tag = "R7";
      else if (e == 7 && p[7]) it.tag = "R2";
      else it.tag = "R1";
      exp_q.push_back(it);
      s = e + 1;
    end
  endtask

  // memory model: one-cycle response
  initial begin
    forever begin
      logic pend;
      logic [AW-1:0] pa;
      @(negedge clk);
      pend = mem_req;
      pa   = mem_addr;
      @(posedge clk);
      #1;
      mem_rvalid = pend;
      mem_rdata  = pend ? fp_words(int'(pa)) : '0;
    end
  end

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  // monitor
  initial begin
    for (int a = 0; a < N_FP; a++) push_fp(a);
    repeat (3) @(negedge clk);
    // R8
    check("R8 reset valid", 256'(ep_valid), 256'(0));
    check("R8 reset mask", 256'(ep_mask), 256'(0));
    check("R8 reset stall", 256'(stall), 256'(0));
    check("R8 reset req", 256'(mem_req), 256'(0));
    rst_n = 1;
    while (!done) begin
      @(negedge clk);
      if (mem_req) begin
        // R6 sequential addresses, R5 no request under stall
        check("R6 req addr", 256'(mem_addr), 256'(exp_req));
        check("R5 req in stall", 256'(stall), 256'(0));
        exp_req++;
      end
      if (edges == 4) check("R6 not yet valid", 256'(ep_valid), 256'(0));
      if (edges == 5) check("R6 first valid", 256'(ep_valid), 256'(1));
      if (!ep_valid) begin
        // R10
        check("R10 mask idle", 256'(ep_mask), 256'(0));
        check("R4 stall idle", 256'(stall), 256'(0));
      end else if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        check({it.tag, " mask"}, 256'(ep_mask), 256'(it.mask));
        // R3 words, R9 data intact through wait stage
        check("R3 R9 words", ep_words, it.words);
        // R4 R5 stall exactly for non-final packets
        check("R4 stall", 256'(stall), 256'(it.stall));
        if (exp_q.size() == 0) done = 1;
      end
      if (edges > 6) check("R3 R5 continuous valid", 256'(ep_valid), 256'(1));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=0 pending", exp_q.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule